// File: doc/BRIEF.md
# Skip and Two-Word Instruction Sequencer

This block steers instruction fetch for a small controller whose instructions are 16 bits wide. It keeps the fetch address, registers each fetched word into an execute slot, and hands that word to the execute unit. The execute unit answers during the same cycle: a skip condition came out true, a conditional branch is taken, or there is an absolute jump (a return, for example) with its own target. The sequencer then works out the next fetch address. Relative branches and calls, and the absolute target carried by the two-word goto and call, are resolved inside the block.

When a word that was already fetched must not run, the sequencer marks its slot as a bubble and presents the all-zero encoding, so the execute unit writes nothing. A skip over a one-word instruction costs one bubble. A skip over a two-word instruction costs two bubbles, because the trailing word is dropped as well. Every change of flow costs exactly one bubble. A trailing word (top nibble 1111) that arrives as a first word runs as a plain NOP.

Top module: `skip_seq`

## Requirements
- R1: While reset is low, and in the first cycle after it, `pc_o` is 0 and `bubble_o` is 1. The first word executed after reset is the one at address 0.
- R2: With no change of flow, `pc_o` advances by one per cycle. `exe_o` shows the word fetched in the previous cycle, `exe_pc_o` shows its address, and `pc_o` equals `exe_pc_o + 1`.
- R3: A word with top nibble 1111 in the execute slot is shown as 16'h0000 with `bubble_o` low.
- R4: `skip_i` high while a live non-branch word executes makes the next word a bubble (`exe_o` 0, `bubble_o` 1).
- R5: If the skipped word is a two-word first word, its trailing word is also a bubble. The two-word first words are: top nibble 1100; top byte 8'hEF; top seven bits 1110110; top ten bits 1110111000.
- R6: `skip_i` low leaves the sequence unchanged.
- R7: A word matching 11100xxx_nnnnnnnn with `take_i` high redirects to (its address + 1 + sign-extended n). This costs one bubble. With `take_i` low it has no effect.
- R8: A word with top nibble 1101 always redirects to (its address + 1 + the sign-extended low 11 bits), with one bubble.
- R9: A goto (8'hEF) or call (1110110x) redirects to {second word[11:0], first word[7:0]}. The second word becomes the bubble.
- R10: `jump_i` high while a live word executes loads `jump_tgt_i` into `pc_o` next cycle, with one bubble. It takes priority over all other redirects and over skip.
- R11: During a bubble cycle, `skip_i`, `take_i`, `jump_i` and `jump_tgt_i` have no effect. `pc_o` advances by one.
- R12: A reset that arrives while a second skip bubble is still pending cancels that bubble. The word at address 0 executes right after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_i | input | 16 | Program word read at `pc_o` |
| skip_i | input | 1 | Skip condition of the executing word is true |
| take_i | input | 1 | Conditional branch of the executing word is taken |
| jump_i | input | 1 | Absolute redirect requested by the execute unit |
| jump_tgt_i | input | PCW | Target for `jump_i` |
| pc_o | output | PCW | Fetch address |
| exe_o | output | 16 | Word to execute, 0 when forced or when it is a trailing word |
| exe_pc_o | output | PCW | Address of the word in the execute slot |
| bubble_o | output | 1 | Execute slot holds a forced NOP |

## Verification
The bench steps a program that skips over a one-word word and over a two-word move, and follows a skip that is not taken. It also runs a taken and a not-taken conditional branch, a relative branch and call, a goto, and a call whose target lands above 8 bits. A design that skipped only one word past a two-word instruction would let a trailing word run after a single bubble. A design with wrong offset sign extension would jump forward instead of backward. All control inputs are held high during every bubble, so a design that let a dropped word act would jump off to the noise target. A reset placed between the two bubbles of a double skip catches a pending bubble that survives reset.

// File: rtl/skip_seq.sv
module skip_seq #(
  parameter int PCW = 20
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [15:0]    instr_i,
  input  logic           skip_i,
  input  logic           take_i,
  input  logic           jump_i,
  input  logic [PCW-1:0] jump_tgt_i,
  output logic [PCW-1:0] pc_o,
  output logic [15:0]    exe_o,
  output logic [PCW-1:0] exe_pc_o,
  output logic           bubble_o
);
  logic [PCW-1:0] pc_q, ir_pc_q, tgt, seq_pc, rel8, rel11;
  logic [15:0]    ir_q;
  logic           bub_q, bub2_q, redir, flush, live;
  logic [19:0]    abs_w;

  function automatic logic two_word(input logic [15:0] w);
    return (w[15:12] == 4'hC) || (w[15:8] == 8'hEF) ||
           (w[15:9] == 7'b1110110) || (w[15:6] == 10'b1110111000);
  endfunction

  assign live   = !bub_q;
  assign seq_pc = ir_pc_q + PCW'(1);
  assign rel8   = {{(PCW-8){ir_q[7]}}, ir_q[7:0]};
  assign rel11  = {{(PCW-11){ir_q[10]}}, ir_q[10:0]};
  assign abs_w  = {instr_i[11:0], ir_q[7:0]};

  always_comb begin
    redir = 1'b0;
    tgt   = seq_pc;
    if (live) begin
      if (jump_i) begin
        redir = 1'b1;
        tgt   = jump_tgt_i;
      end else if (ir_q[15:12] == 4'hD) begin
        redir = 1'b1;
        tgt   = seq_pc + rel11;
      end else if (ir_q[15:11] == 5'b11100 && take_i) begin
        redir = 1'b1;
        tgt   = seq_pc + rel8;
      end else if (ir_q[15:8] == 8'hEF || ir_q[15:9] == 7'b1110110) begin
        redir = 1'b1;
        tgt   = PCW'(abs_w);
      end
    end
  end

  assign flush = live && skip_i && !redir;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q    <= '0;
      ir_q    <= '0;
      ir_pc_q <= '0;
      bub_q   <= 1'b1;
      bub2_q  <= 1'b0;
    end else if (redir) begin
      pc_q   <= tgt;
      bub_q  <= 1'b1;
      bub2_q <= 1'b0;
    end else begin
      pc_q    <= pc_q + PCW'(1);
      ir_q    <= instr_i;
      ir_pc_q <= pc_q;
      bub_q   <= flush | bub2_q;
      bub2_q  <= flush & two_word(instr_i);
    end
  end

  assign pc_o     = pc_q;
  assign exe_o    = (bub_q || ir_q[15:12] == 4'hF) ? 16'h0000 : ir_q;
  assign exe_pc_o = ir_pc_q;
  assign bubble_o = bub_q;
endmodule

module skip_seq_chk #(
  parameter int PCW = 20
) (
  input logic           clk,
  input logic           rst_n,
  input logic           skip_i,
  input logic           jump_i,
  input logic [PCW-1:0] jump_tgt_i,
  input logic [PCW-1:0] pc_o,
  input logic [15:0]    exe_o,
  input logic           bubble_o
);
  AST_RESET_STATE: assert property (@(posedge clk) !rst_n |=> (pc_o == '0 && bubble_o)); // R1
  AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (!bubble_o && !jump_i && !skip_i && exe_o[15:13] != 3'b110 && exe_o[15:13] != 3'b111)
    |=> (pc_o == $past(pc_o) + PCW'(1) && !bubble_o)); // R2
  AST_TRAIL_NOP: assert property (@(posedge clk) disable iff (!rst_n) exe_o[15:12] != 4'hF); // R3
  AST_SKIP_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!bubble_o && skip_i && !jump_i && exe_o[15:14] != 2'b11) |=> bubble_o); // R4
  AST_JUMP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!bubble_o && jump_i) |=> (bubble_o && pc_o == $past(jump_tgt_i))); // R10
  AST_BUBBLE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    bubble_o |=> pc_o == $past(pc_o) + PCW'(1)); // R11
endmodule

bind skip_seq skip_seq_chk #(.PCW(PCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .skip_i(skip_i), .jump_i(jump_i),
  .jump_tgt_i(jump_tgt_i), .pc_o(pc_o), .exe_o(exe_o), .bubble_o(bubble_o)
);

// File: tb/skip_seq_test.sv
module skip_seq_test;
  localparam int PCW = 20;
  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [15:0]    instr_i;
  logic           skip_i = 1'b0, take_i = 1'b0, jump_i = 1'b0;
  logic [PCW-1:0] jump_tgt_i = '0;
  logic [PCW-1:0] pc_o, exe_pc_o;
  logic [15:0]    exe_o;
  logic           bubble_o;

  logic [15:0] mem [256];
  bit          skip_t [256];
  bit          take_t [256];
  bit          jmp_t  [256];
  int          jtgt_t [256];

  int    q_word[$], q_pc[$], q_bub[$];
  string q_tag[$];
  int    checks = 0, fails = 0;
  bit    done = 1'b0;

  always #5 clk = ~clk;

  skip_seq #(.PCW(PCW)) uut (
    .clk(clk), .rst_n(rst_n), .instr_i(instr_i), .skip_i(skip_i), .take_i(take_i),
    .jump_i(jump_i), .jump_tgt_i(jump_tgt_i), .pc_o(pc_o), .exe_o(exe_o),
    .exe_pc_o(exe_pc_o), .bubble_o(bubble_o)
  );

  assign instr_i = mem[pc_o[7:0]];

  function automatic bit is2w(input logic [15:0] w);
    return (w[15:12] == 4'hC) || (w[15:8] == 8'hEF) ||
           (w[15:9] == 7'b1110110) || (w[15:6] == 10'b1110111000);
  endfunction

  function automatic int m20(input int v);
    return v & 32'hFFFFF;
  endfunction

  task automatic push(input int w, input int pc, input int b, input string tag);
    q_word.push_back(w); q_pc.push_back(pc); q_bub.push_back(b); q_tag.push_back(tag);
  endtask

  task automatic build(input int n, input string first_tag);
    int a = 0;
    string nxt = first_tag;
    q_word.delete(); q_pc.delete(); q_bub.delete(); q_tag.delete();
    while (q_word.size() < n) begin
      logic [15:0] w = mem[a & 255];
      logic [15:0] w2 = mem[(a + 1) & 255];
      int off;
      push((w[15:12] == 4'hF) ? 0 : int'(w), a, 0, (w[15:12] == 4'hF) ? "R3" : nxt);
      nxt = "R2";
      if (jmp_t[a & 255]) begin
        a = jtgt_t[a & 255];
        push(0, a, 1, "R10/R11");
      end else if (w[15:12] == 4'hD) begin
        off = w[10] ? int'(w[10:0]) - 2048 : int'(w[10:0]);
        a = m20(a + 1 + off);
        push(0, a, 1, "R8/R11");
      end else if (w[15:11] == 5'b11100 && take_t[a & 255]) begin
        off = w[7] ? int'(w[7:0]) - 256 : int'(w[7:0]);
        a = m20(a + 1 + off);
        push(0, a, 1, "R7/R11");
      end else if (w[15:8] == 8'hEF || w[15:9] == 7'b1110110) begin
        a = int'({w2[11:0], w[7:0]});
        push(0, a, 1, "R9/R11");
      end else if (skip_t[a & 255]) begin
        push(0, m20(a + 2), 1, "R4/R11");
        if (is2w(w2)) begin
          push(0, m20(a + 3), 1, "R5/R11");
          a = m20(a + 3);
        end else a = m20(a + 2);
      end else begin
        if (w[15:11] == 5'b11100) nxt = "R7";
        else if (w[15:12] == 4'h6) nxt = "R6";
        a = m20(a + 1);
      end
    end
  endtask

  task automatic drive();
    if (bubble_o) begin
      skip_i = 1'b1; take_i = 1'b1; jump_i = 1'b1; jump_tgt_i = 20'hAAAAA;
    end else begin
      skip_i = skip_t[exe_pc_o[7:0]];
      take_i = take_t[exe_pc_o[7:0]];
      jump_i = jmp_t[exe_pc_o[7:0]];
      jump_tgt_i = PCW'(jtgt_t[exe_pc_o[7:0]]);
    end
  endtask

  task automatic check_reset(input string tag);
    checks++;
    if (pc_o !== '0 || bubble_o !== 1'b1) begin
      fails++;
      $display("FAIL %s reset: act pc=%h bub=%b exp pc=0 bub=1", tag, pc_o, bubble_o);
    end
  endtask

  task automatic run(input int n);
    repeat (n) begin
      int w, pc, b;
      string tag;
      bit ok;
      @(negedge clk);
      w = q_word.pop_front(); pc = q_pc.pop_front(); b = q_bub.pop_front(); tag = q_tag.pop_front();
      if (b != 0) ok = (bubble_o === 1'b1) && (exe_o === 16'h0) && (int'(pc_o) == pc);
      else ok = (bubble_o === 1'b0) && (int'(exe_o) == w) && (int'(exe_pc_o) == pc) &&
                (int'(pc_o) == m20(pc + 1));
      checks++;
      if (!ok) begin
        fails++;
        $display("FAIL %s: act bub=%b exe=%h exe_pc=%h pc=%h exp bub=%0d exe=%h at=%h",
                 tag, bubble_o, exe_o, exe_pc_o, pc_o, b, w, pc);
      end
      drive();
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 16'h0000; skip_t[i] = 0; take_t[i] = 0; jmp_t[i] = 0; jtgt_t[i] = 0;
    end
    mem[0]  = 16'h0E05;
    mem[1]  = 16'h6201; skip_t[1] = 1;
    mem[2]  = 16'h0F01;
    mem[3]  = 16'h6401; skip_t[3] = 1;
    mem[4]  = 16'hC012;
    mem[5]  = 16'hF034;
    mem[6]  = 16'h6601;
    mem[7]  = 16'hC055;
    mem[8]  = 16'hF066;
    mem[9]  = 16'hE003;
    mem[10] = 16'hE102; take_t[10] = 1;
    mem[11] = 16'h0A00;
    mem[12] = 16'h0B00;
    mem[13] = 16'hD003;
    mem[14] = 16'h0900; mem[15] = 16'h0900; mem[16] = 16'h0900;
    mem[17] = 16'hEF20;
    mem[18] = 16'hF000;
    mem[32] = 16'hED40;
    mem[33] = 16'hF001;
    mem[64] = 16'h6001; skip_t[64] = 1;
    mem[65] = 16'hEF00;
    mem[66] = 16'hF0CD;
    mem[67] = 16'h0E11; jmp_t[67] = 1; jtgt_t[67] = 32'h50;
    mem[80] = 16'h6A01; skip_t[80] = 1;
    mem[81] = 16'hF123;
    mem[82] = 16'hEE10;
    mem[83] = 16'hF0AB;
    mem[84] = 16'hD800;
    mem[85] = 16'hE0FB; take_t[85] = 1;

    repeat (3) begin
      @(negedge clk);
      check_reset("R1");
    end
    rst_n = 1'b1;
    drive();
    build(60, "R1");
    run(60);

    rst_n = 1'b0;
    @(negedge clk);
    check_reset("R1");
    rst_n = 1'b1;
    drive();
    build(5, "R2");
    run(5);
    rst_n = 1'b0;
    @(negedge clk);
    check_reset("R12");
    rst_n = 1'b1;
    drive();
    build(60, "R12");
    run(60);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: act running exp finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule